// File: doc/BRIEF.md
# Byte-Load Parallel-to-Serial Converter

This block lets a host processor push bytes over an 8-bit parallel bus and turns them into an unbroken serial bit stream. The stream is timed by a shift clock that a free-running divider derives from the system clock. A write is decoded from three chip selects and a write strobe. The byte on the bus is taken when the strobe ends. It first lands in a holding slot, and it moves into the shift register at the next falling moment of the shift clock that finds the shifter free. A shifter is free when it is idle or has just put out its last bit.

The host is paced by one ready/busy pin. That pin is low exactly while the holding slot is occupied. It therefore acts as the ready half of a valid/ready pair: a write that ends while ready is low is back-pressured by being dropped, and it sets a sticky overrun flag. How long busy lasts depends on the converter's state. It is under one shift-clock period when the converter is empty. It can approach a full byte time when the shifter still has most of its current byte to send. On the output side, a serial-valid pin marks the shift-clock periods that carry real bits.

Top module: `byte_serializer`

## Requirements
- R1: After reset, rdy is 1, overrun is 0, ser_valid is 0, sdout is 1 and sclk is 0.
- R2: A write is accepted only when cs0_n=0, cs1_n=0, cs2=1 and wr_n=0 hold together on at least MIN_WR_CYC consecutive rising clock edges. A shorter strobe, or a strobe with any select inactive, leaves rdy at 1 and sends no byte.
- R3: The byte written is the din value seen on the last clock edge at which the write was still qualified. din changes after the strobe ends have no effect.
- R4: rdy reads 0 in the clock cycle that follows the first clock edge at which an accepted write is no longer qualified.
- R5: rdy stays 0 while the holding slot is full. It returns to 1 at the same clock edge where sclk falls and the byte enters the shifter. With an empty converter this happens within SCLK_DIV+1 cycles. With a byte still shifting, it waits for that byte's last bit.
- R6: Each byte leaves on sdout least-significant bit first, one bit per sclk period. sdout changes only where sclk falls, so it is stable while sclk is high.
- R7: A byte held while another shifts starts on the very next sclk period after the previous byte's bit 7, with no idle period between them.
- R8: A write that ends while rdy is 0 is ignored. The bytes already queued go out unchanged, and overrun becomes 1 and stays 1 until reset.
- R9: sclk runs freely with a period of SCLK_DIV clock cycles. It is low for the first half of each period and high for the second half.
- R10: ser_valid is 1 exactly for the sclk periods that carry a byte's bits. While no byte is shifting, sdout is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs0_n | input | 1 | Chip select 0, active low |
| cs1_n | input | 1 | Chip select 1, active low |
| cs2 | input | 1 | Chip select 2, active high |
| wr_n | input | 1 | Write strobe, active low |
| din | input | 8 | Host data bus |
| rdy | output | 1 | 1 = ready for a byte, 0 = busy |
| sclk | output | 1 | Shift clock |
| sdout | output | 1 | Serial data, LSB first |
| ser_valid | output | 1 | sdout carries a real bit this sclk period |
| overrun | output | 1 | Sticky: a write was dropped while busy |

## Verification
The assertions assume that the host inputs are synchronous to clk. They also assume that a strobe counts as ended when the decode is first sampled inactive. For that reason the bench changes selects, strobe and data only on falling clock edges. The busy-origin and release properties take for granted that no other source clears the holding slot. The bench never issues a reset in the middle of a run. It also writes bytes only through full strobes of known length, so every fall of rdy can be traced to a strobe that ended two edges earlier.

// File: rtl/bser_pkg.sv
package bser_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              full;
    logic [BYTE_W-1:0] data;
  } slot_t;
endpackage

// File: rtl/bser_wr_qual.sv
module bser_wr_qual
  import bser_pkg::*;
#(
  parameter int MIN_WR_CYC = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs0_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              wr_n,
  input  logic [BYTE_W-1:0] din,
  output logic              sel,
  output logic              commit,
  output logic [BYTE_W-1:0] data
);
  localparam int QW = $clog2(MIN_WR_CYC + 1);
  localparam logic [QW-1:0] RUN_MAX = QW'(MIN_WR_CYC);

  logic [QW-1:0] run;
  logic          sel_q;

  assign sel = !cs0_n && !cs1_n && cs2 && !wr_n;

  // run counts consecutive qualified edges, saturating at the minimum width
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= '0;
      sel_q <= 1'b0;
      data  <= '0;
    end else begin
      sel_q <= sel;
      if (sel) begin
        data <= din;
        if (run != RUN_MAX) run <= run + 1'b1;
      end else begin
        run <= '0;
      end
    end
  end

  // trailing edge of a long-enough strobe
  assign commit = sel_q && !sel && (run == RUN_MAX);
endmodule

// File: rtl/bser_sclk_gen.sv
module bser_sclk_gen #(
  parameter int SCLK_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic sclk,
  output logic fall_tick
);
  localparam int CW   = (SCLK_DIV > 2) ? $clog2(SCLK_DIV) : 1;
  localparam int HALF = SCLK_DIV / 2;
  localparam logic [CW-1:0] LAST  = CW'(SCLK_DIV - 1);
  localparam logic [CW-1:0] HIGHS = CW'(HALF);

  logic [CW-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase <= '0;
    else if (phase == LAST)  phase <= '0;
    else                     phase <= phase + 1'b1;
  end

  // low during the first half of a period, high during the second
  assign sclk      = (phase >= HIGHS);
  assign fall_tick = (phase == LAST);
endmodule

// File: rtl/bser_shift_path.sv
module bser_shift_path
  import bser_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [BYTE_W-1:0] data,
  input  logic              fall_tick,
  output logic              rdy,
  output logic              ser_valid,
  output logic              sdout,
  output logic              overrun
);
  localparam int BW = $clog2(BYTE_W + 1);
  localparam logic [BW-1:0] FULL_CNT = BW'(BYTE_W);
  localparam logic [BW-1:0] ONE      = BW'(1);

  slot_t             hold;
  logic [BYTE_W-1:0] sh;
  logic [BW-1:0]     left;
  logic              ovr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
      sh   <= '1;
      left <= '0;
      ovr  <= 1'b0;
    end else begin
      if (fall_tick) begin
        if (left > ONE) begin
          sh   <= {1'b1, sh[BYTE_W-1:1]};
          left <= left - 1'b1;
        end else if (hold.full) begin
          sh        <= hold.data;
          left      <= FULL_CNT;
          hold.full <= 1'b0;
        end else begin
          sh   <= '1;
          left <= '0;
        end
      end
      if (commit) begin
        if (hold.full) begin
          ovr <= 1'b1;
        end else begin
          hold.data <= data;
          hold.full <= 1'b1;
        end
      end
    end
  end

  assign rdy       = !hold.full;
  assign ser_valid = (left != '0);
  assign sdout     = sh[0];
  assign overrun   = ovr;
endmodule

// File: rtl/byte_serializer.sv
module byte_serializer
  import bser_pkg::*;
#(
  parameter int MIN_WR_CYC = 13,
  parameter int SCLK_DIV   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs0_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              wr_n,
  input  logic [BYTE_W-1:0] din,
  output logic              rdy,
  output logic              sclk,
  output logic              sdout,
  output logic              ser_valid,
  output logic              overrun
);
  logic              wr_sel;
  logic              wr_commit;
  logic [BYTE_W-1:0] wr_data;
  logic              sh_tick;

  bser_wr_qual #(.MIN_WR_CYC(MIN_WR_CYC)) u_qual (
    .clk(clk), .rst_n(rst_n), .cs0_n(cs0_n), .cs1_n(cs1_n), .cs2(cs2),
    .wr_n(wr_n), .din(din), .sel(wr_sel), .commit(wr_commit), .data(wr_data)
  );

  bser_sclk_gen #(.SCLK_DIV(SCLK_DIV)) u_sclk (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .fall_tick(sh_tick)
  );

  bser_shift_path u_path (
    .clk(clk), .rst_n(rst_n), .commit(wr_commit), .data(wr_data),
    .fall_tick(sh_tick), .rdy(rdy), .ser_valid(ser_valid),
    .sdout(sdout), .overrun(overrun)
  );
endmodule

// File: rtl/bser_checker.sv
module bser_checker (
  input logic clk,
  input logic rst_n,
  input logic sel,
  input logic rdy,
  input logic sclk,
  input logic sdout,
  input logic overrun
);
  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R8
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> !$past(rdy));

  // R6
  bit_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdout));

  // R4
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> $past(sel, 2));

  // R5
  ready_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> $fell(sclk));
endmodule

bind byte_serializer bser_checker u_bser_chk (
  .clk(clk), .rst_n(rst_n), .sel(wr_sel), .rdy(rdy),
  .sclk(sclk), .sdout(sdout), .overrun(overrun)
);

// File: tb/test_byte_serializer.sv
module test_byte_serializer;
  localparam int MINW = 13;
  localparam int DIV  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs0_n = 1'b1, cs1_n = 1'b1, cs2 = 1'b0, wr_n = 1'b1;
  logic [7:0] din = 8'h00;
  logic rdy, sclk, sdout, ser_valid, overrun;

  int n_chk = 0, n_fail = 0;

  // receiver model
  logic [7:0] rx_sr = 8'h00;
  int rx_bit = 0, rx_n = 0, rise_idx = 0;
  logic [7:0] rx_buf [0:31];
  int rx_start [0:31];

  always #4 clk = ~clk;

  byte_serializer #(.MIN_WR_CYC(MINW), .SCLK_DIV(DIV)) i_byte_serializer (
    .clk(clk), .rst_n(rst_n), .cs0_n(cs0_n), .cs1_n(cs1_n), .cs2(cs2),
    .wr_n(wr_n), .din(din), .rdy(rdy), .sclk(sclk), .sdout(sdout),
    .ser_valid(ser_valid), .overrun(overrun)
  );

  always @(posedge sclk) begin
    if (ser_valid) begin
      if (rx_bit == 0 && rx_n < 32) rx_start[rx_n] = rise_idx;
      rx_sr = {sdout, rx_sr[7:1]};
      rx_bit++;
      if (rx_bit == 8) begin
        if (rx_n < 32) rx_buf[rx_n] = rx_sr;
        rx_n++;
        rx_bit = 0;
      end
    end
    rise_idx++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] d, input int cyc, input logic c2,
                            input logic [7:0] after_d);
    @(negedge clk);
    cs0_n = 1'b0; cs1_n = 1'b0; cs2 = c2; wr_n = 1'b0; din = d;
    repeat (cyc) @(negedge clk);
    cs0_n = 1'b1; cs1_n = 1'b1; cs2 = 1'b0; wr_n = 1'b1; din = after_d;
  endtask

  task automatic wait_ready(output int k);
    k = 0;
    while (!rdy && k < 200) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(rdy == 1'b1, "R1 rdy", rdy, 1);
    chk(overrun == 1'b0, "R1 overrun", overrun, 0);
    chk(ser_valid == 1'b0, "R1 ser_valid", ser_valid, 0);
    chk(sdout == 1'b1, "R1 sdout", sdout, 1);
    chk(sclk == 1'b0, "R1 sclk", sclk, 0);
  endtask

  task automatic t_clock;
    time t0, t1, t2;
    @(posedge sclk); t0 = $time;
    @(posedge sclk); t1 = $time;
    @(negedge sclk); t2 = $time;
    chk((t1 - t0) == DIV * 8, "R9 period", int'(t1 - t0), DIV * 8);
    chk((t2 - t1) == (DIV / 2) * 8, "R9 high time", int'(t2 - t1), (DIV / 2) * 8);
  endtask

  task automatic t_rejects;
    int n0 = rx_n;
    host_write(8'h11, MINW - 1, 1'b1, 8'h00);
    repeat (3) @(negedge clk);
    chk(rdy == 1'b1, "R2 short strobe rdy", rdy, 1);
    host_write(8'h22, MINW + 2, 1'b0, 8'h00);
    repeat (3) @(negedge clk);
    chk(rdy == 1'b1, "R2 cs2 inactive rdy", rdy, 1);
    repeat (12 * DIV) @(negedge clk);
    chk(rx_n == n0, "R2 no byte sent", rx_n, n0);
  endtask

  task automatic t_single;
    int n0 = rx_n;
    int k;
    host_write(8'hA5, MINW, 1'b1, 8'hFF);
    chk(rdy == 1'b1, "R4 ready before commit", rdy, 1);
    @(negedge clk);
    chk(rdy == 1'b0, "R4 busy after strobe", rdy, 0);
    wait_ready(k);
    chk(k <= DIV + 1, "R5 empty busy length", k, DIV + 1);
    repeat (12 * DIV) @(negedge clk);
    chk(rx_n == n0 + 1, "R6 byte count", rx_n, n0 + 1);
    chk(rx_buf[n0] == 8'hA5, "R6 LSB first value", rx_buf[n0], 8'hA5);
    chk(rx_buf[n0] == 8'hA5, "R3 data after strobe ignored", rx_buf[n0], 8'hA5);
  endtask

  task automatic t_idle;
    chk(ser_valid == 1'b0, "R10 idle valid", ser_valid, 0);
    chk(sdout == 1'b1, "R10 idle sdout", sdout, 1);
  endtask

  task automatic t_back2back;
    int n0 = rx_n;
    int k;
    host_write(8'h3C, MINW, 1'b1, 8'h00);
    wait_ready(k);
    host_write(8'hC3, MINW, 1'b1, 8'h00);
    @(negedge clk);
    chk(rdy == 1'b0, "R4 second write busy", rdy, 0);
    host_write(8'h5A, MINW, 1'b1, 8'h00);
    @(negedge clk);
    chk(overrun == 1'b1, "R8 overrun set", overrun, 1);
    chk(rdy == 1'b0, "R5 busy held while shifting", rdy, 0);
    wait_ready(k);
    chk(k < 200, "R5 long busy ends", k, 0);
    repeat (20 * DIV) @(negedge clk);
    chk(rx_n == n0 + 2, "R8 dropped byte not sent", rx_n, n0 + 2);
    chk(rx_buf[n0] == 8'h3C, "R8 first byte intact", rx_buf[n0], 8'h3C);
    chk(rx_buf[n0 + 1] == 8'hC3, "R8 second byte intact", rx_buf[n0 + 1], 8'hC3);
    chk(rx_start[n0 + 1] - rx_start[n0] == 8, "R7 no gap",
        rx_start[n0 + 1] - rx_start[n0], 8);
    chk(overrun == 1'b1, "R8 overrun sticky", overrun, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_clock();
    t_rejects();
    t_single();
    t_idle();
    t_back2back();
    t_idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule